// File: doc/BRIEF.md
# Stereo Soft Mute Ramp

This block sits in the digital path of a stereo audio output. It scales a pair of 20-bit two's-complement samples by a shared gain. The gain fades to silence when a mute request is raised and fades back to full level when the request is dropped. Full scale is 7FFFFh positive and 80000h negative, and 0 is silence.

The gain changes only on a frame strobe, which comes once per sample period. A full fade therefore lasts 1024 sample frames, whatever the system clock rate. If the request changes during a fade, the gain turns around from the value it has reached. It does not jump to either end.

Both channels are multiplied by the same gain and then scaled down by the full-scale gain with an arithmetic shift. A status output reports when the gain has reached zero.

Top module: `soft_mute_ramp`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) loads the gain with 1024 (muted low) when mute_req is low during reset. It loads the gain with 0 (muted high) when mute_req is high during reset. Reset also clears out_valid and both output samples.
- R2: While mute_req is high, each clock edge with frame_stb high lowers the gain by one until it reaches 0. Starting from full gain, muted is still low after 1023 strobes and goes high after the 1024th.
- R3: While mute_req is low, each clock edge with frame_stb high raises the gain by one until it reaches 1024.
- R4: A change of mute_req during a fade reverses the direction of the fade, starting from the gain value already reached.
- R5: Clock edges with frame_stb low never change the gain.
- R6: At a clock edge with in_valid high, each output sample becomes floor(sample × gain / 1024), using the gain held before that edge. out_valid equals in_valid one clock later. The output samples hold their value while in_valid is low.
- R7: muted is high exactly when the gain is 0. Every valid output produced at gain 0 is exactly zero.
- R8: The left and right channels use the same gain, so equal input samples give equal output samples.
- R9: At gain 1024 the outputs equal the inputs, including 7FFFFh and 80000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per sample frame; advances the fade |
| mute_req | input | 1 | High requests a fade to silence, low a fade to full level |
| in_valid | input | 1 | Input samples are valid this cycle |
| in_left | input | 20 | Left input sample, two's complement |
| in_right | input | 20 | Right input sample, two's complement |
| out_valid | output | 1 | Output samples updated this cycle |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |
| muted | output | 1 | High when the gain is zero |

## Verification
The properties assume that every input is sampled cleanly at the rising clock edge. They also assume that rst_n is held low for at least one edge before any check that looks back a cycle. The stepping properties do not assume that frame_stb comes at a fixed rate: one strobe may be followed by any number of quiet cycles, and the gain must stay put across them. The stimulus changes all inputs on the falling edge. It drives the strobe as a single-cycle pulse, sometimes back to back and sometimes with long gaps. It feeds identical samples to both channels often enough to exercise the channel-matching property.

// File: rtl/smr_pkg.sv
package smr_pkg;

   typedef enum logic [1:0] {
      DIR_HOLD = 2'd0,
      DIR_DOWN = 2'd1,
      DIR_UP   = 2'd2
   } ramp_dir_e;

   function automatic int gain_bits(input int ramp_log2);
      return ramp_log2 + 1;
   endfunction

endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl #(
   parameter int RAMP_LOG2 = 10,
   localparam int GAIN_W = smr_pkg::gain_bits(RAMP_LOG2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              mute_req,
   output logic [GAIN_W-1:0] gain_o,
   output logic              muted_o
);
   import smr_pkg::*;

   localparam logic [GAIN_W-1:0] GAIN_FULL = {1'b1, {RAMP_LOG2{1'b0}}};

   logic [GAIN_W-1:0] level_q;
   ramp_dir_e         dir;

   always_comb begin
      dir = DIR_HOLD;
      if (frame_stb) begin
         if (mute_req && (level_q != '0)) begin
            dir = DIR_DOWN;
         end else if (!mute_req && (level_q != GAIN_FULL)) begin
            dir = DIR_UP;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= mute_req ? '0 : GAIN_FULL;
      end else begin
         unique case (dir)
            DIR_DOWN: level_q <= level_q - 1'b1;
            DIR_UP:   level_q <= level_q + 1'b1;
            default:  level_q <= level_q;
         endcase
      end
   end

   assign gain_o  = level_q;
   assign muted_o = (level_q == '0);

endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
   parameter int DATA_W    = 20,
   parameter int RAMP_LOG2 = 10,
   localparam int GAIN_W = smr_pkg::gain_bits(RAMP_LOG2),
   localparam int PROD_W = DATA_W + GAIN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_in,
   input  logic [GAIN_W-1:0] gain,
   output logic [DATA_W-1:0] smp_out
);
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] scaled;

   // gain is at most 2**RAMP_LOG2, so the shifted product fits in DATA_W bits
   assign prod   = $signed(smp_in) * $signed({1'b0, gain});
   assign scaled = prod >>> RAMP_LOG2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_out <= '0;
      end else if (smp_valid) begin
         smp_out <= DATA_W'(scaled);
      end
   end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
   parameter int DATA_W    = 20,
   parameter int RAMP_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              mute_req,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_left,
   output logic [DATA_W-1:0] out_right,
   output logic              muted
);
   localparam int GAIN_W = smr_pkg::gain_bits(RAMP_LOG2);
   localparam int NUM_CH = 2;

   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
      $error("soft_mute_ramp: DATA_W must lie in 8..32");
   end
   if (RAMP_LOG2 < 2 || RAMP_LOG2 > 16) begin : g_bad_ramp
      $error("soft_mute_ramp: RAMP_LOG2 must lie in 2..16");
   end

   logic [GAIN_W-1:0] gain_q;
   logic              valid_q;
   logic [DATA_W-1:0] ch_in  [NUM_CH];
   logic [DATA_W-1:0] ch_out [NUM_CH];

   smr_gain_ctrl #(
      .RAMP_LOG2(RAMP_LOG2)
   ) gain_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .mute_req (mute_req),
      .gain_o   (gain_q),
      .muted_o  (muted)
   );

   assign ch_in[0] = in_left;
   assign ch_in[1] = in_right;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      smr_scale #(
         .DATA_W   (DATA_W),
         .RAMP_LOG2(RAMP_LOG2)
      ) scale_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .smp_valid(in_valid),
         .smp_in   (ch_in[c]),
         .gain     (gain_q),
         .smp_out  (ch_out[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= in_valid;
      end
   end

   assign out_valid = valid_q;
   assign out_left  = ch_out[0];
   assign out_right = ch_out[1];

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
   parameter int DATA_W    = 20,
   parameter int RAMP_LOG2 = 10,
   localparam int GAIN_W = RAMP_LOG2 + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb,
   input logic              mute_req,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_left,
   input logic [DATA_W-1:0] in_right,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_left,
   input logic [DATA_W-1:0] out_right,
   input logic              muted,
   input logic [GAIN_W-1:0] gain_q
);
   localparam logic [GAIN_W-1:0] GAIN_FULL = {1'b1, {RAMP_LOG2{1'b0}}};

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(frame_stb)) |-> $stable(gain_q)); // R5

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(frame_stb) && $past(mute_req) && ($past(gain_q) != '0))
      |-> (gain_q == $past(gain_q) - 1'b1)); // R2

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(frame_stb) && !$past(mute_req) && ($past(gain_q) != GAIN_FULL))
      |-> (gain_q == $past(gain_q) + 1'b1)); // R3

   AST_SILENT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && $past(muted))
      |-> (out_left == '0 && out_right == '0)); // R7

   AST_CH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(in_left) == $past(in_right)))
      |-> (out_left == out_right)); // R8

   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid))); // R6

endmodule

bind soft_mute_ramp smr_checker #(
   .DATA_W   (DATA_W),
   .RAMP_LOG2(RAMP_LOG2)
) chk_i (.*);

// File: tb/soft_mute_ramp_tb_top.sv
module soft_mute_ramp_tb_top;
   localparam int DW   = 20;
   localparam int FULL = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_stb = 1'b0;
   logic          mute_req = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_left = '0;
   logic [DW-1:0] in_right = '0;
   logic          out_valid;
   logic [DW-1:0] out_left;
   logic [DW-1:0] out_right;
   logic          muted;

   int n_cmp = 0;
   int n_bad = 0;
   int m_gain = FULL;
   int m_left = 0;
   int m_right = 0;
   bit m_valid = 1'b0;

   always #10 clk = ~clk;

   soft_mute_ramp dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .mute_req (mute_req),
      .in_valid (in_valid),
      .in_left  (in_left),
      .in_right (in_right),
      .out_valid(out_valid),
      .out_left (out_left),
      .out_right(out_right),
      .muted    (muted)
   );

   function automatic int sx(input logic [DW-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: update the reference at the edge, compare at the falling edge
   task automatic tick();
      @(posedge clk);
      if (!rst_n) begin
         m_gain  = mute_req ? 0 : FULL;
         m_left  = 0;
         m_right = 0;
         m_valid = 1'b0;
      end else begin
         if (in_valid) begin
            m_left  = (sx(in_left) * m_gain) >>> 10;
            m_right = (sx(in_right) * m_gain) >>> 10;
         end
         m_valid = in_valid;
         if (frame_stb) begin
            if (mute_req && m_gain > 0) m_gain--;
            else if (!mute_req && m_gain < FULL) m_gain++;
         end
      end
      @(negedge clk);
      check("R6 out_valid", int'(out_valid), int'(m_valid));
      check("R7 muted", int'(muted), int'(m_gain == 0));
      check("R6 out_left", sx(out_left), m_left);
      check("R6 out_right", sx(out_right), m_right);
   endtask

   task automatic drive_sample(input bit same);
      in_valid = 1'b1;
      in_left  = DW'($urandom);
      in_right = same ? in_left : DW'($urandom);
   endtask

   // n frames, each a strobe cycle followed by one quiet cycle
   task automatic frames(input int n);
      for (int i = 0; i < n; i++) begin
         frame_stb = 1'b1;
         drive_sample(i % 3 == 0);
         tick();
         frame_stb = 1'b0;
         in_valid = (i % 5 != 0);
         tick();
      end
   endtask

   task automatic probe(input logic [DW-1:0] l, input logic [DW-1:0] r);
      frame_stb = 1'b0;
      in_valid = 1'b1;
      in_left = l;
      in_right = r;
      tick();
      in_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      tick();
      tick();
      check("R1 reset muted low", int'(muted), 0);
      check("R1 reset out_valid", int'(out_valid), 0);
      rst_n = 1'b1;
      tick();

      // R9: unity gain passes full scale both ways
      probe(20'h7FFFF, 20'h80000);
      check("R9 left full scale", sx(out_left), 524287);
      check("R9 right full scale", sx(out_right), -524288);
      frames(20);

      // R2: 1023 strobes leave the gain at 1, the next reaches zero
      mute_req = 1'b1;
      frames(1023);
      check("R2 muted after 1023", int'(muted), 0);
      probe(20'h7FFFF, 20'h80000);
      check("R2 gain one left", sx(out_left), 511);
      check("R2 gain one right", sx(out_right), -512);
      frames(1);
      check("R2 muted after 1024", int'(muted), 1);
      frames(10);
      probe(20'h7FFFF, 20'h80000);
      check("R7 silent left", sx(out_left), 0);
      check("R7 silent right", sx(out_right), 0);

      // R3 and R4: partial rise, reverse, rise again to full
      mute_req = 1'b0;
      frames(300);
      mute_req = 1'b1;
      frames(100);
      probe(20'h40000, 20'h40000);
      check("R4 reversal gain 200", sx(out_left), 51200);
      check("R8 matched channels", sx(out_right), 51200);
      mute_req = 1'b0;
      frames(50);
      probe(20'h40000, 20'hC0000);
      check("R4 reversed up to 250", sx(out_left), 64000);
      check("R8 mirrored channel", sx(out_right), -64000);

      // R5: long stretch without strobes keeps the gain
      mute_req = 1'b1;
      for (int i = 0; i < 60; i++) begin
         drive_sample(1'b1);
         tick();
      end
      probe(20'h40000, 20'h40000);
      check("R5 no strobe hold", sx(out_left), 64000);

      // R6: outputs hold while in_valid is low
      in_valid = 1'b0;
      in_left = 20'h12345;
      tick();
      check("R6 hold left", sx(out_left), 64000);

      mute_req = 1'b0;
      frames(800);
      probe(20'h80000, 20'h7FFFF);
      check("R3 back at full left", sx(out_left), -524288);
      check("R3 back at full right", sx(out_right), 524287);
      frames(5);

      // R1: reset with request high starts muted
      rst_n = 1'b0;
      mute_req = 1'b1;
      tick();
      tick();
      rst_n = 1'b1;
      check("R1 reset muted high", int'(muted), 1);
      probe(20'h7FFFF, 20'h7FFFF);
      check("R1 muted output zero", sx(out_left), 0);
      mute_req = 1'b0;
      frames(4);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule